// File: doc/BRIEF.md
# Self-compacting bubble queue

This block is a first-in first-out queue built as a chain of word stages rather than a RAM with read and write pointers. Each stage holds one data word and a hidden occupancy flag. A word written at the input stage moves one stage per clock toward the output end while the stage ahead of it is free. It stops behind the nearest occupied stage and keeps its value there. Only the occupancy flags decide emptiness; the data bits never do.

The consumer sees the word in the output (head) stage together with a valid flag. It removes that word with an advance command. Two further commands are available: one drops the newest word still in the queue, and one clears every stage at once. The producer pushes words while `full` is low. `full` reports that the input stage is occupied, so a burst of pushes is accepted at most every other cycle while the words behind it drain forward.

Top module: `bubble_queue`

## Requirements
- R1: After reset is released, `empty` is 1, `full` is 0 and `head_valid` is 0.
- R2: A word pushed into an empty queue moves one stage per rising edge. It appears at the head, with `head_valid` 1, after exactly DEPTH rising edges counted from the edge that accepts it, and not earlier.
- R3: Words leave the head in the order they were pushed, with their data unchanged.
- R4: A word never moves into an occupied stage. When advance is not asserted, DEPTH accepted words pack all stages, and `full` then stays 1.
- R5: A push while `full` is 1 is ignored. Draining afterwards yields only the words accepted before it.
- R6: Advance removes the head word, and the next word becomes the head. Advance while `head_valid` is 0 has no effect.
- R7: Erase deletes the newest word in the queue, which is the occupied stage nearest the input. The older words are kept in order.
- R8: Clear empties every stage at the next rising edge and has priority over push, advance and erase issued in the same cycle.
- R9: A push and an advance in the same cycle both take effect.
- R10: `empty` is 1 exactly when no stage is occupied, and `full` is 1 exactly when the input stage is occupied. `empty` and `head_valid` are never both 1.
- R11: Erase also deletes the newest word while that word is moving between stages. A single word in transit is then gone at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push | input | 1 | Write strobe; accepted only when `full` is 0 |
| push_data | input | WIDTH | Word to write |
| advance | input | 1 | Discard the head word |
| erase | input | 1 | Delete the newest word |
| clear | input | 1 | Empty all stages |
| head_data | output | WIDTH | Word in the output stage |
| head_valid | output | 1 | Output stage holds a word |
| full | output | 1 | Input stage occupied; a push is refused |
| empty | output | 1 | No stage occupied |

## Verification
The stage-level properties assume that the top gates each push with the input stage's free flag. They also assume that the kill masks from advance and erase mark at most one stage each. The bench's write task therefore waits for `full` to be low before it raises `push`. It drives push while full only in the scenario meant to test that the push is refused. All commands are held for one clock and driven on the falling edge. Erase is exercised both on a settled queue and on a word still moving. This makes the transit case of the kill path visible at the ports through `empty` and the drained order.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int unsigned BQ_WORD_W = 8;
  localparam int unsigned BQ_STAGES = 8;
  localparam int unsigned BQ_SYNC_FF = 2;
endpackage

// File: rtl/bq_rst_sync.sv
module bq_rst_sync #(
  parameter int unsigned NFF = bq_pkg::BQ_SYNC_FF
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [NFF-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[NFF-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[NFF-1];
endmodule

// File: rtl/bq_newest_find.sv
module bq_newest_find #(
  parameter int unsigned DEPTH = bq_pkg::BQ_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] occ,
  output logic [DEPTH-1:0] newest
);
  logic [DEPTH:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < DEPTH; i++) begin : g_scan
    assign below[i+1] = below[i] | occ[i];
    assign newest[i]  = occ[i] & ~below[i];
  end

  // R7: erase never targets more than one stage
  p_single_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(newest));
  // R7: a non-empty chain always yields a target
  p_target_exists_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|occ) |-> ($countones(newest) == 1));
endmodule

// File: rtl/bq_stage.sv
module bq_stage #(
  parameter int unsigned W = bq_pkg::BQ_WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         up_occ,
  input  logic         up_kill,
  input  logic [W-1:0] up_data,
  input  logic         dn_occ,
  input  logic         kill,
  output logic         occ,
  output logic [W-1:0] data
);
  logic         occ_q, occ_d;
  logic [W-1:0] data_q, data_d;
  logic         data_en, move_in, move_out;

  always_comb begin
    move_in  = up_occ & ~occ_q;
    move_out = occ_q & ~dn_occ;
    if (clr) begin
      occ_d   = 1'b0;
      data_en = 1'b0;
    end else begin
      occ_d   = (occ_q & ~move_out & ~kill) | (move_in & ~up_kill) | load;
      data_en = (move_in & ~up_kill) | load;
    end
    data_d = load ? load_data : up_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= 1'b0;
      data_q <= '0;
    end else begin
      occ_q <= occ_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign occ  = occ_q;
  assign data = data_q;

  // R5: the top only loads a free input stage
  p_load_into_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !occ_q);
  // R4: a blocked word keeps its place and value
  p_blocked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && dn_occ && !kill && !clr) |=> (occ_q && $stable(data_q)));
  // R2: a stage that hands its word forward frees itself
  p_handoff_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && !dn_occ && !clr) |=> !occ_q);
endmodule

// File: rtl/bubble_queue.sv
module bubble_queue #(
  parameter int unsigned WIDTH = bq_pkg::BQ_WORD_W,
  parameter int unsigned DEPTH = bq_pkg::BQ_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             advance,
  input  logic             erase,
  input  logic             clear,
  output logic [WIDTH-1:0] head_data,
  output logic             head_valid,
  output logic             full,
  output logic             empty
);
  localparam int unsigned LAST = DEPTH - 1;

  logic                       rst_sync_n;
  logic [DEPTH-1:0]           occ;
  logic [DEPTH-1:0][WIDTH-1:0] data;
  logic [DEPTH-1:0]           newest;
  logic [DEPTH-1:0]           kill;
  logic                       accept;

  bq_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  bq_newest_find #(.DEPTH(DEPTH)) u_find (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .occ    (occ),
    .newest (newest)
  );

  always_comb begin
    accept = push & ~occ[0];
    kill   = erase ? newest : '0;
    kill[LAST] = kill[LAST] | advance;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_in
      bq_stage #(.W(WIDTH)) u_stage (
        .clk (clk), .rst_n (rst_sync_n), .clr (clear),
        .load (accept), .load_data (push_data),
        .up_occ (1'b0), .up_kill (1'b0), .up_data ('0),
        .dn_occ ((DEPTH == 1) ? 1'b1 : occ[(DEPTH == 1) ? 0 : 1]),
        .kill (kill[i]), .occ (occ[i]), .data (data[i])
      );
    end else begin : g_mid
      bq_stage #(.W(WIDTH)) u_stage (
        .clk (clk), .rst_n (rst_sync_n), .clr (clear),
        .load (1'b0), .load_data ('0),
        .up_occ (occ[i-1]), .up_kill (kill[i-1]), .up_data (data[i-1]),
        .dn_occ ((i == LAST) ? 1'b1 : occ[(i == LAST) ? i : i+1]),
        .kill (kill[i]), .occ (occ[i]), .data (data[i])
      );
    end
  end

  assign head_data  = data[LAST];
  assign head_valid = occ[LAST];
  assign full       = occ[0];
  assign empty      = ~|occ;

  // R8: clear leaves nothing behind
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear |=> (empty && !full && !head_valid));
  // R10: no head word on an empty queue
  p_empty_no_head_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(empty && head_valid));
  // R6: a held head without advance or erase stays put
  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (head_valid && !advance && !erase && !clear) |=> (head_valid && $stable(head_data)));
endmodule

// File: tb/bubble_queue_bench.sv
module bubble_queue_bench;
  localparam int unsigned W = 8;
  localparam int unsigned D = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic push, advance, erase, clear;
  logic [W-1:0] push_data;
  logic [W-1:0] head_data;
  logic head_valid, full, empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bubble_queue #(.WIDTH(W), .DEPTH(D)) u_bubble_queue (
    .clk (clk), .rst_n (rst_n), .push (push), .push_data (push_data),
    .advance (advance), .erase (erase), .clear (clear),
    .head_data (head_data), .head_valid (head_valid), .full (full), .empty (empty)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    push = 0; advance = 0; erase = 0; clear = 0;
  endtask

  task automatic settle();
    for (int k = 0; k < 2*D + 4; k++) step();
  endtask

  task automatic put(input logic [W-1:0] v);
    while (full) step();
    push = 1; push_data = v;
    step();
    push = 0;
  endtask

  task automatic take(input string req, input logic [W-1:0] exp);
    int guard = 0;
    while (!head_valid && guard < 3*D) begin step(); guard++; end
    check(req, {7'b0, head_valid}, 8'd1);
    check(req, head_data, exp);
    advance = 1;
    step();
    advance = 0;
  endtask

  task automatic expect_empty(input string req);
    settle();
    check(req, {7'b0, empty}, 8'd1);
    check(req, {7'b0, head_valid}, 8'd0);
  endtask

  task automatic t_reset();
    check("R1 empty", {7'b0, empty}, 8'd1);
    check("R1 full", {7'b0, full}, 8'd0);
    check("R1 head_valid", {7'b0, head_valid}, 8'd0);
    advance = 1; step(); advance = 0;
    check("R6 advance on empty", {7'b0, empty}, 8'd1);
  endtask

  task automatic t_latency();
    push = 1; push_data = 8'hA5;
    step();
    push = 0;
    check("R10 full after accept", {7'b0, full}, 8'd1);
    check("R10 not empty", {7'b0, empty}, 8'd0);
    for (int k = 0; k < D-2; k++) step();
    check("R2 not yet at head", {7'b0, head_valid}, 8'd0);
    step();
    check("R2 at head after DEPTH edges", {7'b0, head_valid}, 8'd1);
    check("R2 data", head_data, 8'hA5);
    check("R10 full low once moved", {7'b0, full}, 8'd0);
    advance = 1; step(); advance = 0;
    check("R6 removed", {7'b0, head_valid}, 8'd0);
    check("R10 empty again", {7'b0, empty}, 8'd1);
  endtask

  task automatic t_fill_order();
    for (int k = 0; k < D; k++) put(8'h11 * (k + 1));
    settle();
    check("R4 packed full", {7'b0, full}, 8'd1);
    check("R4 head is oldest", head_data, 8'h11);
    push = 1; push_data = 8'hEE; step(); push = 0;
    settle();
    for (int k = 0; k < D; k++) take("R3 R5 drain order", 8'h11 * (k + 1));
    expect_empty("R5 refused push absent");
  endtask

  task automatic t_erase();
    put(8'h21); put(8'h22); put(8'h23);
    settle();
    erase = 1; step(); erase = 0;
    settle();
    take("R7 keep oldest", 8'h21);
    take("R7 keep second", 8'h22);
    expect_empty("R7 newest gone");
    push = 1; push_data = 8'h31; step(); push = 0;
    erase = 1; step(); erase = 0;
    check("R11 transit word erased", {7'b0, empty}, 8'd1);
    expect_empty("R11 stays empty");
  endtask

  task automatic t_push_adv();
    put(8'h41); put(8'h42);
    settle();
    push = 1; push_data = 8'h43; advance = 1;
    step();
    idle();
    check("R9 push taken", {7'b0, full}, 8'd1);
    settle();
    take("R9 head after advance", 8'h42);
    take("R9 pushed word", 8'h43);
    expect_empty("R9 drained");
  endtask

  task automatic t_clear();
    put(8'h51); put(8'h52); put(8'h53);
    settle();
    clear = 1; push = 1; push_data = 8'h5F; advance = 1; erase = 1;
    step();
    idle();
    check("R8 empty next edge", {7'b0, empty}, 8'd1);
    check("R8 full low", {7'b0, full}, 8'd0);
    check("R8 head_valid low", {7'b0, head_valid}, 8'd0);
    expect_empty("R8 push with clear ignored");
  endtask

  initial begin
    idle();
    push_data = '0;
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    t_reset();
    t_latency();
    t_fill_order();
    t_erase();
    t_push_adv();
    t_clear();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule